// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block sits on the host side of a byte-wide flash device and programs one byte with a closed pulse-and-verify loop. A client hands it an address and a data byte over a valid/ready handshake. The sequencer then drives a simple single-cycle bus toward the flash. Each attempt writes the program-setup command, then the target address with its data byte. It waits out the program pulse, writes the program-verify command, and reads the byte back. If the read-back differs from the requested byte, the whole attempt is repeated. The number of attempts is bounded.

When the loop ends, the sequencer writes the read-array command so the device returns to normal reads. It then raises a one-cycle done strobe. A pass/fail flag and the number of program pulses spent are held on the status outputs until the next request is accepted. The pulse length, counted in clock cycles, and the attempt limit are parameters. Bus read data is expected one cycle after the read strobe.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `reqReady` is 1, `doneStb`, `busWrEn` and `busRdEn` are 0, `donePass` is 0 and `doneTries` is 0.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` stays 0 from that edge until the done strobe has been given. A `reqValid` raised while busy causes no bus access to its address and no extra done strobe.
- R3: Every attempt begins with a bus write of the setup code 0x40. It is followed in the very next cycle by a bus write of the requested data byte to the requested address. The program write therefore happens once per attempt.
- R4: Exactly `PULSE_CYCLES` cycles without any bus access separate the program write from the verify-command write (code 0xC0).
- R5: The cycle after the verify-command write carries a read strobe at the requested address. The read data is sampled in the following cycle.
- R6: When the sampled byte equals the requested byte, the result is pass. `doneTries` gives the number of attempts made.
- R7: On a mismatch the sequence restarts at the setup write, as long as fewer than `MAX_TRIES` attempts have been made. A mismatch on attempt `MAX_TRIES` ends with fail and `doneTries` = `MAX_TRIES`.
- R8: After pass or fail, a bus write of the read-array code 0x00 is issued. The one-cycle `doneStb` follows in the next cycle. `donePass` and `doneTries` then hold their values until the next request is accepted.
- R9: Counting the first setup cycle as cycle 0, `doneStb` is high in cycle tries*(`PULSE_CYCLES`+5)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqAddr | input | ADDR_W | Byte address to program |
| reqData | input | 8 | Byte value to program |
| busWrEn | output | 1 | Single-cycle bus write strobe |
| busRdEn | output | 1 | Single-cycle bus read strobe |
| busAddr | output | ADDR_W | Bus address |
| busWrData | output | 8 | Bus write data (command code or data byte) |
| busRdData | input | 8 | Read data, valid the cycle after busRdEn |
| doneStb | output | 1 | One-cycle completion strobe |
| donePass | output | 1 | 1 when the last byte verified |
| doneTries | output | CNT_W | Program pulses spent on the last byte |

## Verification
The bench sweeps every address of a small configuration, using a flash model that needs a different number of pulses per address. This covers the first-pulse pass, passes one short of the limit, a pass exactly at the limit, and counts that exceed it. A design that checked the limit one attempt early or late would report the wrong pass flag or pulse count at that boundary. A design that miscounted the pulse wait would show up in the gap measured between the program and verify writes, and in the end-to-end latency. A request raised mid-sequence is checked for stray bus traffic. The model also flags a read strobe outside verify mode and a missing trailing read-array write.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam logic [7:0] CMD_SETUP  = 8'h40;
  localparam logic [7:0] CMD_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ   = 8'h00;

  typedef enum logic [1:0] {
    WSEL_SETUP,
    WSEL_DATA,
    WSEL_VERIFY,
    WSEL_READ
  } wrSel_e;

  typedef struct packed {
    logic   latchReq;
    logic   incTry;
    logic   loadTimer;
    logic   decTimer;
    logic   wrEn;
    logic   rdEn;
    wrSel_e wrSel;
    logic   saveResult;
  } strobes_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PROG,
    ST_PULSE,
    ST_VERIFY,
    ST_READ,
    ST_CMP,
    ST_FINISH,
    ST_DONE
  } state_e;

endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PULSE_CYCLES = 1250,
  parameter int MAX_TRIES    = 25,
  localparam int CNT_W       = $clog2(MAX_TRIES + 1),
  localparam int TMR_W       = $clog2(PULSE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        busRdData,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              timerDone,
  output logic              match,
  output logic              lastTry,
  output logic              resPass,
  output logic [CNT_W-1:0]  resTries
);

  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TRY_MAX  = CNT_W'(MAX_TRIES);

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic [CNT_W-1:0]  triesQ;
  logic [TMR_W-1:0]  timerQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.latchReq) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triesQ <= '0;
    end else if (stb.latchReq) begin
      triesQ <= '0;
    end else if (stb.incTry) begin
      triesQ <= triesQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (stb.loadTimer) begin
      timerQ <= TMR_LOAD;
    end else if (stb.decTimer && timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPass  <= 1'b0;
      resTries <= '0;
    end else if (stb.saveResult) begin
      resPass  <= match;
      resTries <= triesQ;
    end
  end

  assign timerDone = (timerQ == '0);
  assign match     = (busRdData == dataQ);
  assign lastTry   = (triesQ == TRY_MAX);

  always_comb begin
    unique case (stb.wrSel)
      WSEL_SETUP:  busWrData = CMD_SETUP;
      WSEL_DATA:   busWrData = dataQ;
      WSEL_VERIFY: busWrData = CMD_VERIFY;
      default:     busWrData = CMD_READ;
    endcase
  end

  assign busWrEn = stb.wrEn;
  assign busRdEn = stb.rdEn;
  assign busAddr = addrQ;

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    triesQ <= TRY_MAX) else $error("tries over limit"); // R7
  AST_ONE_BUS_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn)) else $error("write and read together"); // R5
  AST_TIMER_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTimer |=> timerQ == TMR_LOAD) else $error("timer not loaded"); // R4

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     timerDone,
  input  logic     match,
  input  logic     lastTry,
  output logic     reqReady,
  output logic     doneStb,
  output strobes_t stb
);

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    stb.wrSel = WSEL_READ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateD = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stb.wrEn   = 1'b1;
        stb.wrSel  = WSEL_SETUP;
        stb.incTry = 1'b1;
        stateD = ST_PROG;
      end
      ST_PROG: begin
        stb.wrEn      = 1'b1;
        stb.wrSel     = WSEL_DATA;
        stb.loadTimer = 1'b1;
        stateD = ST_PULSE;
      end
      ST_PULSE: begin
        stb.decTimer = 1'b1;
        if (timerDone) stateD = ST_VERIFY;
      end
      ST_VERIFY: begin
        stb.wrEn  = 1'b1;
        stb.wrSel = WSEL_VERIFY;
        stateD = ST_READ;
      end
      ST_READ: begin
        stb.rdEn = 1'b1;
        stateD = ST_CMP;
      end
      ST_CMP: begin
        if (match || lastTry) begin
          stb.saveResult = 1'b1;
          stateD = ST_FINISH;
        end else begin
          stateD = ST_SETUP;
        end
      end
      ST_FINISH: begin
        stb.wrEn  = 1'b1;
        stb.wrSel = WSEL_READ;
        stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign doneStb  = (stateQ == ST_DONE);

  AST_VERIFY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_VERIFY |-> ($past(stateQ) == ST_PULSE && $past(timerDone)))
    else $error("verify before pulse end"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb && reqReady) else $error("done longer than a cycle"); // R8
  AST_RETRY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CMP && !match && !lastTry) |=> stateQ == ST_SETUP)
    else $error("no retry after miss"); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady) else $error("ready while busy"); // R2

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PULSE_CYCLES = 1250,
  parameter int MAX_TRIES    = 25,
  localparam int CNT_W       = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  input  logic [7:0]        busRdData,
  output logic              doneStb,
  output logic              donePass,
  output logic [CNT_W-1:0]  doneTries
);

  strobes_t stb;
  logic     timerDone;
  logic     match;
  logic     lastTry;

  fps_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .timerDone(timerDone),
    .match    (match),
    .lastTry  (lastTry),
    .reqReady (reqReady),
    .doneStb  (doneStb),
    .stb      (stb)
  );

  fps_datapath #(
    .ADDR_W      (ADDR_W),
    .PULSE_CYCLES(PULSE_CYCLES),
    .MAX_TRIES   (MAX_TRIES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .busRdData(busRdData),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .timerDone(timerDone),
    .match    (match),
    .lastTry  (lastTry),
    .resPass  (donePass),
    .resTries (doneTries)
  );

  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && !donePass) |-> doneTries == CNT_W'(MAX_TRIES))
    else $error("fail below limit"); // R7
  AST_READ_AFTER_VERIFY: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> $past(busWrEn && busWrData == CMD_VERIFY))
    else $error("read not preceded by verify"); // R5

endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;

  localparam int AW  = 4;
  localparam int P   = 4;
  localparam int MX  = 6;
  localparam int CW  = $clog2(MX + 1);
  localparam int NA  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          busWrEn, busRdEn;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWrData;
  logic [7:0]    busRdData;
  logic          doneStb, donePass;
  logic [CW-1:0] doneTries;

  always #4 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .PULSE_CYCLES(P), .MAX_TRIES(MX)) i_flash_prog_seq (
    .clk, .rstN, .reqValid, .reqReady, .reqAddr, .reqData,
    .busWrEn, .busRdEn, .busAddr, .busWrData, .busRdData,
    .doneStb, .donePass, .doneTries
  );

  // flash model
  logic [7:0] mem   [NA];
  int         need  [NA];
  int         progCnt [NA];
  logic [7:0] rdReg = 8'hFF;
  bit expectProg = 0, verifyMode = 0, inGap = 0, lastWasRead = 0;
  int gapCnt = 0, gapErr = 0, seqErr = 0, rdErr = 0, badAddr = 0;
  logic [AW-1:0] curAddr = '0;

  assign busRdData = rdReg;

  always @(posedge clk) begin
    if (rstN) begin
      if (busWrEn) begin
        if (busAddr != curAddr) badAddr++;
        if (expectProg) begin
          expectProg = 0;
          progCnt[busAddr]++;
          if (progCnt[busAddr] >= need[busAddr]) mem[busAddr] = busWrData;
          inGap = 1; gapCnt = 0;
        end else if (busWrData == 8'h40) begin
          expectProg = 1; verifyMode = 0; lastWasRead = 0;
        end else if (busWrData == 8'hC0) begin
          if (!inGap || gapCnt != P) gapErr++;
          inGap = 0; verifyMode = 1;
        end else if (busWrData == 8'h00) begin
          verifyMode = 0; lastWasRead = 1;
        end
      end else begin
        if (expectProg) begin seqErr++; expectProg = 0; end
        if (busRdEn) begin
          if (!verifyMode || busAddr != curAddr) rdErr++;
          rdReg <= mem[busAddr];
          inGap = 0;
        end else if (inGap) gapCnt++;
      end
    end
  end

  int errors = 0, checks = 0, cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic [AW-1:0] a, input logic [7:0] d, input int nd,
                        input bit spur);
    int expTries, k, e0, s0, r0, b0;
    bit expPass, busyReady;
    logic [AW-1:0] sa;
    sa = a ^ 4'hF;
    for (int i = 0; i < NA; i++) begin progCnt[i] = 0; mem[i] = 8'hFF; need[i] = 99; end
    need[a] = nd;
    curAddr = a;
    e0 = gapErr; s0 = seqErr; r0 = rdErr; b0 = badAddr;
    expPass  = (nd <= MX);
    expTries = expPass ? nd : MX;
    @(negedge clk);
    check(reqReady == 1'b1, "R2 ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    k = 0; busyReady = 0;
    while (!doneStb && k < 2000) begin
      if (reqReady) busyReady = 1;
      if (spur && k == P + 2) begin reqValid = 1'b1; reqAddr = sa; reqData = ~d; end
      if (spur && k == P + 5) reqValid = 1'b0;
      @(negedge clk);
      k++;
    end
    check(!busyReady, "R2 ready low while busy", busyReady, 0);
    check(k == expTries * (P + 5) + 1, "R9 latency", k, expTries * (P + 5) + 1);
    check(donePass == expPass, "R6/R7 pass flag", donePass, expPass);
    check(int'(doneTries) == expTries, "R6/R7 tries", doneTries, expTries);
    check(progCnt[a] == expTries, "R3 program writes", progCnt[a], expTries);
    check(gapErr == e0, "R4 pulse gap", gapErr - e0, 0);
    check(seqErr == s0, "R3 setup then program", seqErr - s0, 0);
    check(rdErr == r0, "R5 read in verify mode", rdErr - r0, 0);
    check(lastWasRead, "R8 read-array write before done", lastWasRead, 1);
    if (expPass) check(mem[a] == d, "R6 byte stored", mem[a], d);
    if (spur) begin
      check(badAddr == b0, "R2 busy request ignored", badAddr - b0, 0);
      check(progCnt[sa] == 0, "R2 no program at spurious addr", progCnt[sa], 0);
    end
    @(negedge clk);
    check(!doneStb, "R8 done one cycle", doneStb, 0);
    check(donePass == expPass && int'(doneTries) == expTries, "R8 status held",
          doneTries, expTries);
  endtask

  initial begin
    for (int i = 0; i < NA; i++) begin mem[i] = 8'hFF; need[i] = 1; progCnt[i] = 0; end
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready", reqReady, 1);
    check(!doneStb && !busWrEn && !busRdEn, "R1 quiet bus", busWrEn, 0);
    check(!donePass && doneTries == '0, "R1 status zero", doneTries, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busWrEn && !busRdEn && reqReady, "R1 idle after reset", busWrEn, 0);
    for (int a = 0; a < NA; a++)
      runReq(a[AW-1:0], {a[3:0], ~a[3:0]}, (a % 8) + 1, a == 5);
    for (int a = 0; a < NA; a++)
      runReq(a[AW-1:0], {~a[3:0], a[3:0]}, ((a * 3) % 9) + 1, 0);
    runReq(4'd9, 8'h5A, MX, 1);
    runReq(4'd9, 8'hA5, MX + 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule